// File: doc/BRIEF.md
# Rolling Shutter Windowed Row Sequencer

This block walks a rectangular window of a pixel array in raster order and hands out one read address per accepted beat. It also drives a second row pointer that trails the read row by a programmable number of rows. Each time reading starts on a new row, it emits a strobe that puts the trailing row into reset and starts its integration again. The distance between the two pointers is the only thing that sets exposure time.

Window bounds and the trailing distance come in on plain configuration pins. They are sampled only when a frame starts. A frame starts when `run` is high while the sequencer is idle. If `sync_en` is set at that moment, reading waits for a `sync_pulse`. A configuration that breaks an ordering or range rule raises `cfg_err` and no frame starts.

Read addresses leave the block on a valid/ready stream. The consumer's `rd_ready` acts as the pixel clock enable. A beat is accepted on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the row and column hold still. The reset strobe and the end-of-frame pulse are tied to accepted beats, so back-pressure delays them as well.

Top module: `rs_window_seq`

## Requirements
- R1: After reset, `rd_valid`, `rst_stb`, `eof` and `cfg_err` are all 0.
- R2: Within a frame, accepted beats visit columns `cfg_col_start`..`cfg_col_stop` inclusive for each row, and rows `cfg_row_start`..`cfg_row_stop` inclusive in ascending order.
- R3: While `rd_valid` is 1 and `rd_ready` is 0, `rd_row` and `rd_col` hold their values and no beat is accepted.
- R4: `rst_stb` is 1 exactly on accepted beats whose column equals the window's start column, so it fires once per row read.
- R5: When `rst_stb` is 1, `rst_row` equals `row_start + ((rd_row - row_start - holdoff) mod H)`, where H = `row_stop - row_start + 1`.
- R6: With a holdoff of 0, `rst_row` equals `rd_row` on every strobe.
- R7: `eof` is 1 for exactly one cycle, on the accepted beat at (`row_stop`, `col_stop`). `rd_valid` is 0 in the following cycle.
- R8: A start request is refused, with `cfg_err` set to 1 and `rd_valid` kept at 0, if any of these holds: row stop ≤ row start, column stop ≤ column start, a stop index at or beyond the array size, or holdoff ≥ H. The next accepted start clears `cfg_err`.
- R9: If `sync_en` is 1 at the start request, `rd_valid` stays 0 until the cycle after `sync_pulse` is seen high.
- R10: Changes on the configuration pins during a frame have no effect on that frame's addresses or strobes.
- R11: With `sync_en` at 0, `rd_valid` rises on the cycle after a valid `run` is sampled in idle. If `run` stays high, the next frame starts after exactly one idle cycle following `eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Frame start request, sampled while idle |
| sync_en | input | 1 | Wait for `sync_pulse` before reading |
| sync_pulse | input | 1 | External frame sync |
| cfg_row_start | input | AW | First window row |
| cfg_row_stop | input | AW | Last window row |
| cfg_col_start | input | AW | First window column |
| cfg_col_stop | input | AW | Last window column |
| cfg_holdoff | input | AW | Rows between the reset pointer and the read pointer |
| rd_ready | input | 1 | Consumer accepts the current address (pixel enable) |
| rd_valid | output | 1 | Read address is valid |
| rd_row | output | AW | Read row address |
| rd_col | output | AW | Read column address |
| rst_row | output | AW | Row to reset and return to integration |
| rst_stb | output | 1 | Reset strobe for `rst_row` |
| eof | output | 1 | Final beat of the frame accepted |
| cfg_err | output | 1 | Last start request had an invalid configuration |

## Verification
The bench builds the sequencer on an 8-row by 6-column array, which gives 3-bit addresses. At that size every legal row window can be combined with every legal holdoff, which exercises every wrap of the trailing pointer. Three column windows are used, including the narrowest legal one. A 6-column array also lets the range check be driven with stop indices past the last column. Each sweep runs once with `rd_ready` held high and once with pseudo-random back-pressure, so the hold behaviour is seen at every column position.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SYNC = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rs_cfg_check.sv
module rs_cfg_check #(
  parameter int ROWS = 1026,
  parameter int COLS = 1026,
  parameter int AW   = 11
) (
  input  logic [AW-1:0] row_lo,
  input  logic [AW-1:0] row_hi,
  input  logic [AW-1:0] col_lo,
  input  logic [AW-1:0] col_hi,
  input  logic [AW-1:0] holdoff,
  output logic [AW:0]   height,
  output logic          ok
);
  localparam logic [AW:0] ROW_LIM = (AW+1)'(ROWS);
  localparam logic [AW:0] COL_LIM = (AW+1)'(COLS);

  always_comb begin
    height = {1'b0, row_hi} - {1'b0, row_lo} + (AW+1)'(1);
    ok = (row_lo < row_hi) && (col_lo < col_hi) &&
         ({1'b0, row_hi} < ROW_LIM) && ({1'b0, col_hi} < COL_LIM) &&
         ({1'b0, holdoff} < height);
  end
endmodule

// File: rtl/rs_scan_ctr.sv
module rs_scan_ctr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_row,
  input  logic [AW-1:0] ld_col,
  input  logic [AW-1:0] col_lo,
  input  logic [AW-1:0] col_hi,
  input  logic [AW-1:0] row_hi,
  output logic [AW-1:0] row,
  output logic [AW-1:0] col,
  output logic          at_end
);
  assign at_end = (row == row_hi) && (col == col_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (load) begin
      row <= ld_row;
      col <= ld_col;
    end else if (step) begin
      if (col == col_hi) begin
        col <= col_lo;
        if (row != row_hi) row <= row + AW'(1);
      end else begin
        col <= col + AW'(1);
      end
    end
  end

  // R2: column steps by one inside a row, row steps by one at the row end
  p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && col != col_hi) |=> (col == $past(col) + AW'(1)));
  p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && col == col_hi && !at_end) |=>
      (row == $past(row) + AW'(1) && col == $past(col_lo)));
endmodule

// File: rtl/rs_reset_row.sv
module rs_reset_row #(
  parameter int AW = 11
) (
  input  logic [AW-1:0] rd_row,
  input  logic [AW-1:0] row_lo,
  input  logic [AW:0]   height,
  input  logic [AW-1:0] holdoff,
  output logic [AW-1:0] rst_row
);
  logic [AW-1:0] offset;
  logic [AW:0]   wrapped;

  always_comb begin
    offset  = rd_row - row_lo;
    wrapped = {1'b0, rd_row} + height - {1'b0, holdoff};
    if (offset >= holdoff) rst_row = rd_row - holdoff;
    else                   rst_row = wrapped[AW-1:0];
  end
endmodule

// File: rtl/rs_window_seq.sv
module rs_window_seq
  import rs_seq_pkg::*;
#(
  parameter int ROWS = 1026,
  parameter int COLS = 1026,
  parameter int AW   = $clog2((ROWS > COLS) ? ROWS : COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sync_en,
  input  logic          sync_pulse,
  input  logic [AW-1:0] cfg_row_start,
  input  logic [AW-1:0] cfg_row_stop,
  input  logic [AW-1:0] cfg_col_start,
  input  logic [AW-1:0] cfg_col_stop,
  input  logic [AW-1:0] cfg_holdoff,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_row,
  output logic [AW-1:0] rd_col,
  output logic [AW-1:0] rst_row,
  output logic          rst_stb,
  output logic          eof,
  output logic          cfg_err
);
  seq_state_t    state;
  logic [AW-1:0] win_rs, win_re, win_cs, win_ce, win_ho;
  logic [AW:0]   win_h;
  logic [AW:0]   cfg_h;
  logic          cfg_ok;
  logic          start_req, load, beat, at_end;

  rs_cfg_check #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_chk (
    .row_lo(cfg_row_start), .row_hi(cfg_row_stop),
    .col_lo(cfg_col_start), .col_hi(cfg_col_stop),
    .holdoff(cfg_holdoff), .height(cfg_h), .ok(cfg_ok)
  );

  assign start_req = (state == SEQ_IDLE) && run;
  assign load      = start_req && cfg_ok;
  assign rd_valid  = (state == SEQ_RUN);
  assign beat      = rd_valid && rd_ready;
  assign eof       = beat && at_end;
  assign rst_stb   = beat && (rd_col == win_cs);

  rs_scan_ctr #(.AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(load), .step(beat),
    .ld_row(cfg_row_start), .ld_col(cfg_col_start),
    .col_lo(win_cs), .col_hi(win_ce), .row_hi(win_re),
    .row(rd_row), .col(rd_col), .at_end(at_end)
  );

  rs_reset_row #(.AW(AW)) u_trail (
    .rd_row(rd_row), .row_lo(win_rs), .height(win_h),
    .holdoff(win_ho), .rst_row(rst_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cfg_err <= 1'b0;
      win_rs  <= '0;
      win_re  <= '0;
      win_cs  <= '0;
      win_ce  <= '0;
      win_ho  <= '0;
      win_h   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (run) begin
          if (cfg_ok) begin
            cfg_err <= 1'b0;
            win_rs  <= cfg_row_start;
            win_re  <= cfg_row_stop;
            win_cs  <= cfg_col_start;
            win_ce  <= cfg_col_stop;
            win_ho  <= cfg_holdoff;
            win_h   <= cfg_h;
            state   <= sync_en ? SEQ_SYNC : SEQ_RUN;
          end else begin
            cfg_err <= 1'b1;
          end
        end
        SEQ_SYNC: if (sync_pulse) state <= SEQ_RUN;
        SEQ_RUN:  if (eof) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  // R3: address held under back-pressure
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_row) && $stable(rd_col)));
  // R2: read address inside the latched window
  p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_col >= win_cs && rd_col <= win_ce &&
                  rd_row >= win_rs && rd_row <= win_re));
  // R5: trailing row inside the window
  p_trail_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb |-> (rst_row >= win_rs && rst_row <= win_re));
  // R6: zero holdoff resets the row being read
  p_ho_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb && win_ho == '0) |-> (rst_row == rd_row));
  // R7: frame ends after the last beat
  p_eof_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !rd_valid);
  // R8: refused configuration leaves the sequencer idle
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !rd_valid);
  // R9: no reading before the sync pulse
  p_sync_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_SYNC && !sync_pulse) |=> !rd_valid);
endmodule

// File: tb/rs_window_seq_bench.sv
module rs_window_seq_bench;
  localparam int ROWS = 8;
  localparam int COLS = 6;
  localparam int AW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, sync_en = 1'b0, sync_pulse = 1'b0, rd_ready = 1'b0;
  logic [AW-1:0] c_rs = '0, c_re = '0, c_cs = '0, c_ce = '0, c_ho = '0;
  logic rd_valid, rst_stb, eof, cfg_err;
  logic [AW-1:0] rd_row, rd_col, rst_row;

  int checks = 0;
  int errors = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  rs_window_seq #(.ROWS(ROWS), .COLS(COLS)) u_rs_window_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_en(sync_en), .sync_pulse(sync_pulse),
    .cfg_row_start(c_rs), .cfg_row_stop(c_re), .cfg_col_start(c_cs),
    .cfg_col_stop(c_ce), .cfg_holdoff(c_ho), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_row(rd_row), .rd_col(rd_col), .rst_row(rst_row),
    .rst_stb(rst_stb), .eof(eof), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit next_ready();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0] | lfsr[2];
  endfunction

  task automatic set_cfg(input int rs, input int re, input int cs, input int ce, input int ho);
    c_rs = AW'(rs); c_re = AW'(re); c_cs = AW'(cs); c_ce = AW'(ce); c_ho = AW'(ho);
  endtask

  // Runs one frame from idle; checks every cycle against an arithmetic model.
  task automatic run_frame(input int rs, input int re, input int cs, input int ce,
                           input int ho, input bit bp, input bit scramble);
    int er, ec, h;
    bit done;
    h = re - rs + 1;
    @(negedge clk);
    set_cfg(rs, re, cs, ce, ho);
    sync_en = 1'b0;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk("R11 start", int'(rd_valid), 1);
    chk("R8 err cleared", int'(cfg_err), 0);
    if (scramble) set_cfg(0, 1, 0, 1, 1); // R10: new values mid-frame
    er = rs; ec = cs; done = 1'b0;
    while (!done) begin
      rd_ready = bp ? next_ready() : 1'b1;
      #1;
      chk("R3 valid", int'(rd_valid), 1);
      chk("R2 row", int'(rd_row), er);
      chk("R2 col", int'(rd_col), ec);
      chk("R4 stb", int'(rst_stb), int'(rd_ready && ec == cs));
      if (rd_ready && ec == cs) begin
        chk("R5 rst_row", int'(rst_row), rs + ((er - rs - ho + h) % h));
        if (ho == 0) chk("R6 rst_row", int'(rst_row), er);
      end
      chk("R7 eof", int'(eof), int'(rd_ready && er == re && ec == ce));
      if (rd_ready) begin
        if (er == re && ec == ce) done = 1'b1;
        else if (ec == ce) begin ec = cs; er++; end
        else ec++;
      end
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk("R7 valid after eof", int'(rd_valid), 0);
    chk("R7 eof single", int'(eof), 0);
  endtask

  task automatic bad_cfg(input int rs, input int re, input int cs, input int ce, input int ho);
    @(negedge clk);
    set_cfg(rs, re, cs, ce, ho);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk("R8 err set", int'(cfg_err), 1);
    chk("R8 idle", int'(rd_valid), 0);
    @(negedge clk);
    chk("R8 still idle", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 eof", int'(eof), 0);
    chk("R1 rst_stb", int'(rst_stb), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(rd_valid), 0);

    // R2 R4 R5 R6: all row windows and holdoffs, three column windows, two ready modes
    for (int bp = 0; bp < 2; bp++)
      for (int cw = 0; cw < 3; cw++)
        for (int rs = 0; rs < ROWS; rs++)
          for (int re = rs + 1; re < ROWS; re++)
            for (int ho = 0; ho <= re - rs; ho++)
              run_frame(rs, re, (cw == 2) ? 4 : cw * 2, (cw == 0) ? 5 : (cw == 1) ? 3 : 5,
                        ho, bp[0], 1'b0);

    // R10: configuration changes during a frame
    run_frame(2, 6, 1, 4, 3, 1'b1, 1'b1);
    run_frame(0, 7, 0, 5, 7, 1'b0, 1'b1);

    // R8: refused configurations, then a valid start clears the flag
    bad_cfg(3, 3, 0, 5, 0);
    bad_cfg(5, 2, 0, 5, 0);
    bad_cfg(0, 4, 3, 2, 0);
    bad_cfg(0, 4, 0, 6, 0);
    bad_cfg(0, 4, 1, 7, 0);
    bad_cfg(1, 4, 0, 5, 4);
    run_frame(1, 4, 0, 5, 3, 1'b0, 1'b0);

    // R9: sync wait
    @(negedge clk);
    set_cfg(0, 1, 0, 1, 1);
    sync_en = 1'b1;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R9 waiting", int'(rd_valid), 0);
      @(negedge clk);
    end
    sync_pulse = 1'b1;
    chk("R9 before pulse edge", int'(rd_valid), 0);
    @(negedge clk);
    sync_pulse = 1'b0;
    sync_en = 1'b0;
    chk("R9 after pulse", int'(rd_valid), 1);
    rd_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R9 frame eof", int'(eof), int'(i == 3));
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk("R9 frame done", int'(rd_valid), 0);

    // R11: run held high gives back-to-back frames with one idle cycle
    @(negedge clk);
    set_cfg(2, 3, 1, 2, 0);
    run = 1'b1;
    rd_ready = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 4; i++) begin
        #1;
        chk("R11 beat valid", int'(rd_valid), 1);
        chk("R11 eof", int'(eof), int'(i == 3));
        @(negedge clk);
      end
      chk("R11 idle gap", int'(rd_valid), 0);
      @(negedge clk);
    end
    run = 1'b0;
    #1;
    chk("R11 third frame start", int'(rd_valid), 1);
    chk("R11 restart row", int'(rd_row), 2);
    for (int i = 0; i < 4; i++) @(negedge clk);
    rd_ready = 1'b0;
    chk("R11 end", int'(rd_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule